// File: doc/BRIEF.md
# Left-Justified Serial Audio Receiver

This block takes in stereo audio sent over a three-wire serial link and turns it into parallel words. The three wires are a bit clock, a frame clock and a data line. The link uses left-justified framing: the most significant bit of each channel is in the first bit slot after a frame clock edge, with no one-bit delay. While the frame clock is low the bits belong to the left channel. While it is high they belong to the right channel. A stereo pair is complete when the right half ends. At that point both words appear at the same time on the outputs, together with a single-cycle strobe.

All logic runs on the master clock. The bit clock can come from two places. In external mode it is driven from outside, oversampled and edge-detected. In internal mode the block makes it from the master clock divided by eight, and drives it out so the sender can shift data on it. A master/frame ratio of 256, 384 or 512 then gives 16, 24 or 32 bit clocks per channel half (32, 48 or 64 per frame). A ratio code from an external detector turns internal mode on or off. Each channel keeps at most 24 bits. Longer slots lose their trailing bits, and shorter words are zero-filled at the low end.

Top module: `lj_serial_audio_rx`

## Requirements
- R1: While reset is held and right after it, `sample_l`, `sample_r`, `sample_vld` and `bit_clk_out` are all 0.
- R2: The data bit is taken on each rising bit clock. The first bit after a frame clock edge lands in bit 23 of the word, and later bits fill downward. Frame clock 0 fills `sample_l` and frame clock 1 fills `sample_r`.
- R3: A channel slot shorter than 24 bits gives a word whose unfilled low bits are 0.
- R4: Bits after the 24th in a channel slot are ignored.
- R5: When the frame clock goes from high to low after a complete left half and right half, `sample_vld` is high for exactly one cycle, and both words change in that same cycle. The first valid after reset needs a full left half that began after reset.
- R6: In internal mode with a usable ratio code, `bit_clk_out` is the master clock divided by 8: high for 4 cycles, then low for 4.
- R7: The internal divider restarts on each frame clock edge. If the frame clock input changes just before master clock edge 1, `bit_clk_out` is low after edges 3 to 6 and high after edge 7, whatever its phase was before.
- R8: Ratio code 2'b11 means no usable ratio (2'b00=256, 2'b01=384, 2'b10=512). In internal mode with that code, `bit_clk_out` stays 0 and no valid is produced.
- R9: In external mode (`int_clk_sel`=0), `bit_clk_out` stays 0 and frames are received at any frame clock duty cycle, for example 25%.
- R10: Between valid strobes, `sample_l` and `sample_r` do not change, whatever arrives on the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | Master clock; every register runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_clk_sel | input | 1 | 1: make the bit clock internally; 0: use `bit_clk_ext` |
| ratio_code | input | 2 | Detected master/frame ratio: 0=256, 1=384, 2=512, 3=none |
| bit_clk_ext | input | 1 | Bit clock from outside (external mode) |
| frame_clk | input | 1 | Frame clock: 0 = left half, 1 = right half |
| ser_data | input | 1 | Serial data, MSB first |
| bit_clk_out | output | 1 | Internal bit clock, held 0 when not in use |
| sample_l | output | 24 | Left word of the last completed pair |
| sample_r | output | 24 | Right word of the last completed pair |
| sample_vld | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The assertions assume the bit clock, frame clock and data line are synchronous to the master clock as far as the two-stage synchronizer can see. External bit clock phases last at least two master cycles. Frame clock and data change only while the bit clock is low, and never in the same master cycle as a rising bit clock. In internal mode they also assume the sender changes data and frame clock only on the 8-cycle grid that follows `bit_clk_out`. The stimulus follows these rules in both modes. In external mode every change is made on a falling bit clock, three or four master cycles before the next rise. In internal mode each bit is held for exactly eight master cycles, starting at a frame clock edge. The ratio code is changed only while reset is held.

// File: rtl/lj_rx_pkg.sv
package lj_rx_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_LEFT  = 2'd1,
    FR_RIGHT = 2'd2
  } fr_state_e;

  typedef enum logic [1:0] {
    RATIO_256  = 2'd0,
    RATIO_384  = 2'd1,
    RATIO_512  = 2'd2,
    RATIO_NONE = 2'd3
  } ratio_e;

endpackage

// File: rtl/lj_rx_sync.sv
module lj_rx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_n;

  always_comb begin
    stg_n = {stg_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_n;
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/lj_rx_bitclk_div.sv
module lj_rx_bitclk_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic realign,
  output logic bclk,
  output logic rise
);

  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    if (!en || realign) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign bclk = cnt_q[CW-1];
  assign rise = en && (cnt_q == CW'(HALF));

endmodule

// File: rtl/lj_rx_chan_shift.sv
module lj_rx_chan_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] word
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  word_q, word_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    word_n = word_q;
    cnt_n  = cnt_q;
    if (clear) begin
      word_n = '0;
      cnt_n  = '0;
    end else if (shift && (cnt_q < CW'(W))) begin
      for (int i = 0; i < W; i++) begin
        if (cnt_q == CW'(W - 1 - i)) begin
          word_n[i] = bit_in;
        end
      end
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_n;
      cnt_q  <= cnt_n;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/lj_serial_audio_rx.sv
module lj_serial_audio_rx
  import lj_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int DIV         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_master,
  input  logic                rst_n,
  input  logic                int_clk_sel,
  input  logic [1:0]          ratio_code,
  input  logic                bit_clk_ext,
  input  logic                frame_clk,
  input  logic                ser_data,
  output logic                bit_clk_out,
  output logic [SAMPLE_W-1:0] sample_l,
  output logic [SAMPLE_W-1:0] sample_r,
  output logic                sample_vld
);

  localparam int NCH = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk_master or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  // input synchronizer: bit clock, frame clock, data share one delay
  logic [2:0] sync_s;
  lj_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk_master),
    .rst_n(rst_core_n),
    .din  ({bit_clk_ext, frame_clk, ser_data}),
    .dout (sync_s)
  );

  logic bc_s, lr_s, sd_s;
  assign bc_s = sync_s[2];
  assign lr_s = sync_s[1];
  assign sd_s = sync_s[0];

  // edge history and mode tracking
  logic bc_d_q, lr_d_q, mode_q;
  logic bc_d_n, lr_d_n, mode_n;

  always_comb begin
    bc_d_n = bc_s;
    lr_d_n = lr_s;
    mode_n = int_clk_sel;
  end

  always_ff @(posedge clk_master or negedge rst_core_n) begin
    if (!rst_core_n) begin
      bc_d_q <= 1'b0;
      lr_d_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      bc_d_q <= bc_d_n;
      lr_d_q <= lr_d_n;
      mode_q <= mode_n;
    end
  end

  logic lr_edge, lr_rise, lr_fall, ext_rise, mode_chg;
  assign lr_edge  = lr_s ^ lr_d_q;
  assign lr_rise  = lr_s & ~lr_d_q;
  assign lr_fall  = ~lr_s & lr_d_q;
  assign ext_rise = bc_s & ~bc_d_q;
  assign mode_chg = mode_q ^ int_clk_sel;

  logic ratio_ok, div_en, active;
  assign ratio_ok = (ratio_code != RATIO_NONE);
  assign div_en   = int_clk_sel && ratio_ok;
  assign active   = !int_clk_sel || ratio_ok;

  // internal bit clock
  logic int_rise;
  lj_rx_bitclk_div #(.DIV(DIV)) u_div (
    .clk    (clk_master),
    .rst_n  (rst_core_n),
    .en     (div_en),
    .realign(lr_edge),
    .bclk   (bit_clk_out),
    .rise   (int_rise)
  );

  logic bit_rise;
  assign bit_rise = int_clk_sel ? int_rise : ext_rise;

  // per-channel shift registers
  logic [NCH-1:0][SAMPLE_W-1:0] chan_word;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic ch_sel, ch_clr, ch_shf;
    assign ch_sel = (lr_s == 1'(ch));
    assign ch_clr = active && lr_edge && ch_sel;
    assign ch_shf = active && bit_rise && !lr_edge && ch_sel;

    lj_rx_chan_shift #(.W(SAMPLE_W)) u_chan (
      .clk   (clk_master),
      .rst_n (rst_core_n),
      .clear (ch_clr),
      .shift (ch_shf),
      .bit_in(sd_s),
      .word  (chan_word[ch])
    );
  end

  // frame tracking and output staging
  fr_state_e             st_q, st_n;
  logic                  emit;
  logic [SAMPLE_W-1:0]   out_l_q, out_l_n, out_r_q, out_r_n;
  logic                  vld_q, vld_n;

  always_comb begin
    st_n = st_q;
    emit = 1'b0;
    if (!active || mode_chg) begin
      st_n = FR_IDLE;
    end else if (lr_fall) begin
      emit = (st_q == FR_RIGHT);
      st_n = FR_LEFT;
    end else if (lr_rise && (st_q == FR_LEFT)) begin
      st_n = FR_RIGHT;
    end
  end

  always_comb begin
    out_l_n = emit ? chan_word[0] : out_l_q;
    out_r_n = emit ? chan_word[1] : out_r_q;
    vld_n   = emit;
  end

  always_ff @(posedge clk_master or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q    <= FR_IDLE;
      out_l_q <= '0;
      out_r_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      out_l_q <= out_l_n;
      out_r_q <= out_r_n;
      vld_q   <= vld_n;
    end
  end

  assign sample_l   = out_l_q;
  assign sample_r   = out_r_q;
  assign sample_vld = vld_q;

endmodule

// File: rtl/lj_serial_audio_rx_chk.sv
module lj_serial_audio_rx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk_master,
  input logic                rst_n,
  input logic                int_clk_sel,
  input logic [1:0]          ratio_code,
  input logic                bit_clk_out,
  input logic [SAMPLE_W-1:0] sample_l,
  input logic [SAMPLE_W-1:0] sample_r,
  input logic                sample_vld
);

  // R5: the strobe never lasts two cycles
  assert_vld_single_R5: assert property (@(posedge clk_master) disable iff (!rst_n)
    sample_vld |=> !sample_vld);

  // R9: external mode keeps the generated bit clock quiet
  assert_bclk_quiet_ext_R9: assert property (@(posedge clk_master) disable iff (!rst_n)
    !int_clk_sel |=> !bit_clk_out);

  // R8: no usable ratio stops the internal bit clock
  assert_bclk_quiet_noratio_R8: assert property (@(posedge clk_master) disable iff (!rst_n)
    (int_clk_sel && ratio_code == 2'b11) |=> !bit_clk_out);

  // R8: no usable ratio produces no samples
  assert_no_vld_noratio_R8: assert property (@(posedge clk_master) disable iff (!rst_n)
    (int_clk_sel && ratio_code == 2'b11) |=> !sample_vld);

  // R10: words move only together with the strobe
  assert_left_hold_R10: assert property (@(posedge clk_master) disable iff (!rst_n)
    !sample_vld |-> $stable(sample_l));

  assert_right_hold_R10: assert property (@(posedge clk_master) disable iff (!rst_n)
    !sample_vld |-> $stable(sample_r));

endmodule

bind lj_serial_audio_rx lj_serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk_master (clk_master),
  .rst_n      (rst_n),
  .int_clk_sel(int_clk_sel),
  .ratio_code (ratio_code),
  .bit_clk_out(bit_clk_out),
  .sample_l   (sample_l),
  .sample_r   (sample_r),
  .sample_vld (sample_vld)
);

// File: tb/lj_serial_audio_rx_tb_top.sv
module lj_serial_audio_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        int_clk_sel;
  logic [1:0]  ratio_code;
  logic        bit_clk_ext;
  logic        frame_clk;
  logic        ser_data;
  logic        bit_clk_out;
  logic [23:0] sample_l, sample_r;
  logic        sample_vld;

  always #5 clk = ~clk;

  lj_serial_audio_rx dut_i (
    .clk_master (clk),
    .rst_n      (rst_n),
    .int_clk_sel(int_clk_sel),
    .ratio_code (ratio_code),
    .bit_clk_ext(bit_clk_ext),
    .frame_clk  (frame_clk),
    .ser_data   (ser_data),
    .bit_clk_out(bit_clk_out),
    .sample_l   (sample_l),
    .sample_r   (sample_r),
    .sample_vld (sample_vld)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int vld_cnt = 0;
  int dbl_cnt = 0;
  int bhi_cnt = 0;
  logic prev_vld = 1'b0;
  logic [23:0] cap_l [64];
  logic [23:0] cap_r [64];

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_vld) begin
        cap_l[vld_cnt % 64] = sample_l;
        cap_r[vld_cnt % 64] = sample_r;
        vld_cnt = vld_cnt + 1;
        if (prev_vld) dbl_cnt = dbl_cnt + 1;
      end
      if (bit_clk_out) bhi_cnt = bhi_cnt + 1;
    end
    prev_vld = sample_vld;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(input logic [63:0] w, input int n);
    logic [23:0] r;
    r = w[63:40];
    for (int i = 0; i < 24; i++) begin
      if (i >= n) r[23-i] = 1'b0;
    end
    return r;
  endfunction

  task automatic do_reset(input logic imode, input logic [1:0] rc);
    @(negedge clk);
    rst_n = 1'b0;
    int_clk_sel = imode;
    ratio_code = rc;
    frame_clk = 1'b1;
    bit_clk_ext = 1'b0;
    ser_data = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic ext_half(input logic lvl, input logic [63:0] w, input int n,
                          input int hl, input int hh);
    for (int i = 0; i < n; i++) begin
      frame_clk = lvl;
      ser_data = w[63-i];
      repeat (hl) @(negedge clk);
      bit_clk_ext = 1'b1;
      repeat (hh) @(negedge clk);
      bit_clk_ext = 1'b0;
    end
  endtask

  task automatic int_half(input logic lvl, input logic [63:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      frame_clk = lvl;
      ser_data = w[63-i];
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    int_clk_sel = 1'b1;
    ratio_code = 2'b00;
    frame_clk = 1'b0;
    bit_clk_ext = 1'b0;
    ser_data = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 left in reset", {8'h0, sample_l}, 32'h0);
    check("R1 right in reset", {8'h0, sample_r}, 32'h0);
    check("R1 valid in reset", {31'h0, sample_vld}, 32'h0);
    check("R1 bit clock in reset", {31'h0, bit_clk_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bit clock after release", {31'h0, bit_clk_out}, 32'h0);
  endtask

  task automatic t_ext_24;
    int base, dbl0;
    logic [63:0] a, b, c, d;
    logic [23:0] hl_l, hl_r;
    a = 64'hA5C3_F1E7_0000_0000; b = 64'h1234_56FF_0000_0000;
    c = 64'h8000_01AA_0000_0000; d = 64'hFEDC_BA98_0000_0000;
    do_reset(1'b0, 2'b11);
    base = vld_cnt; dbl0 = dbl_cnt;
    ext_half(1'b0, a, 24, 4, 4); ext_half(1'b1, b, 24, 4, 4);
    ext_half(1'b0, c, 24, 3, 3); ext_half(1'b1, d, 24, 3, 3);
    ext_half(1'b0, 64'h0, 4, 3, 3);
    repeat (10) @(negedge clk);
    check("R5 two pairs", vld_cnt - base, 2);
    check("R2 frame1 left", {8'h0, cap_l[base % 64]}, {8'h0, exp_word(a, 24)});
    check("R2 frame1 right", {8'h0, cap_r[base % 64]}, {8'h0, exp_word(b, 24)});
    check("R2 frame2 left", {8'h0, cap_l[(base+1) % 64]}, {8'h0, exp_word(c, 24)});
    check("R2 frame2 right", {8'h0, cap_r[(base+1) % 64]}, {8'h0, exp_word(d, 24)});
    check("R5 single-cycle strobe", dbl_cnt - dbl0, 0);
    check("R9 bit clock quiet in external mode", {31'h0, bit_clk_out}, 32'h0);
    // R10: more data on the same half, no frame edge
    hl_l = sample_l; hl_r = sample_r; base = vld_cnt;
    ext_half(1'b0, 64'h5A5A_5A5A_5A5A_5A5A, 40, 3, 3);
    repeat (6) @(negedge clk);
    check("R10 no strobe without edge", vld_cnt - base, 0);
    check("R10 left held", {8'h0, sample_l}, {8'h0, hl_l});
    check("R10 right held", {8'h0, sample_r}, {8'h0, hl_r});
  endtask

  task automatic t_ext_short_long;
    int base;
    logic [63:0] a, b;
    a = 64'hBEEF_FFFF_FFFF_FFFF; b = 64'hC0FF_EE12_3456_789A;
    do_reset(1'b0, 2'b00);
    base = vld_cnt;
    ext_half(1'b0, a, 16, 4, 4); ext_half(1'b1, b, 48, 4, 4);
    ext_half(1'b0, 64'h0, 4, 4, 4);
    repeat (10) @(negedge clk);
    check("R9 one pair at 25% duty", vld_cnt - base, 1);
    check("R3 short word padded", {8'h0, cap_l[base % 64]}, {8'h0, exp_word(a, 16)});
    check("R4 long slot truncated", {8'h0, cap_r[base % 64]}, {8'h0, exp_word(b, 48)});
  endtask

  task automatic t_first_frame;
    int base;
    do_reset(1'b0, 2'b00);
    base = vld_cnt;
    ext_half(1'b1, 64'hFFFF_0000_0000_0000, 8, 3, 3);
    ext_half(1'b0, 64'hFFFF_0000_0000_0000, 8, 3, 3);
    ext_half(1'b1, 64'h0F0F_0F00_0000_0000, 24, 3, 3);
    ext_half(1'b0, 64'h0, 4, 3, 3);
    repeat (10) @(negedge clk);
    check("R5 partial pair after reset dropped", vld_cnt - base, 1);
    check("R5 first full pair right", {8'h0, cap_r[base % 64]}, 32'h000F_0F0F);
  endtask

  task automatic t_int_free;
    int hi, lo, guard;
    do_reset(1'b1, 2'b01);
    guard = 0;
    while (bit_clk_out !== 1'b0 && guard < 20) begin @(negedge clk); guard++; end
    while (bit_clk_out !== 1'b1 && guard < 40) begin @(negedge clk); guard++; end
    hi = 0; lo = 0;
    while (bit_clk_out === 1'b1 && hi < 20) begin hi++; @(negedge clk); end
    while (bit_clk_out === 1'b0 && lo < 20) begin lo++; @(negedge clk); end
    check("R6 internal bit clock high cycles", hi, 4);
    check("R6 internal bit clock low cycles", lo, 4);
  endtask

  task automatic t_int_realign(input int phase);
    logic [7:0] seen;
    do_reset(1'b1, 2'b10);
    repeat (phase) @(negedge clk);
    frame_clk = ~frame_clk;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      seen[k] = bit_clk_out;
    end
    check("R7 low after edges 3..6", {28'h0, seen[6:3]}, 32'h0);
    check("R7 high after edge 7", {31'h0, seen[7]}, 32'h1);
  endtask

  task automatic t_int_frame(input logic [1:0] rc, input int n);
    int base;
    logic [63:0] a, b;
    a = 64'hD3C2_B1A0_9F8E_7D6C; b = 64'h6B5A_4938_2716_0504;
    do_reset(1'b1, rc);
    base = vld_cnt;
    int_half(1'b0, a, n); int_half(1'b1, b, n);
    int_half(1'b0, 64'h0, 4);
    repeat (10) @(negedge clk);
    check("R7 internal pair count", vld_cnt - base, 1);
    check("R2 internal left", {8'h0, cap_l[base % 64]}, {8'h0, exp_word(a, n)});
    check("R2 internal right", {8'h0, cap_r[base % 64]}, {8'h0, exp_word(b, n)});
  endtask

  task automatic t_no_ratio;
    int base, bh;
    do_reset(1'b1, 2'b11);
    base = vld_cnt; bh = bhi_cnt;
    int_half(1'b0, 64'hFFFF_FFFF_0000_0000, 16);
    int_half(1'b1, 64'hFFFF_FFFF_0000_0000, 16);
    int_half(1'b0, 64'h0, 4);
    repeat (10) @(negedge clk);
    check("R8 no bit clock without ratio", bhi_cnt - bh, 0);
    check("R8 no strobe without ratio", vld_cnt - base, 0);
    check("R8 left untouched", {8'h0, sample_l}, 32'h0);
  endtask

  logic wd_hit = 1'b0;

  initial begin
    rst_n = 1'b0; int_clk_sel = 1'b0; ratio_code = 2'b00;
    bit_clk_ext = 1'b0; frame_clk = 1'b1; ser_data = 1'b0;
    fork
      begin
        t_reset();
        t_ext_24();
        t_ext_short_long();
        t_first_frame();
        t_int_free();
        t_int_realign(3);
        t_int_realign(6);
        t_int_frame(2'b00, 16);
        t_int_frame(2'b01, 24);
        t_int_frame(2'b10, 32);
        t_no_ratio();
      end
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule